// File: doc/BRIEF.md
# 64-bit Accumulator ALU with Flag Write Mask

This block performs one accumulator operation per request for a 64-bit accumulator machine. A request (`start_i` high at a clock edge) carries an operation code, the accumulator value, a 64-bit operand and the current carry flag. At that edge the block computes the result and the Negative, Overflow, Zero and Carry flags, and registers them. It also registers a per-flag write-enable mask and a result write-enable, so the surrounding datapath keeps any flag, or the accumulator, that the operation does not touch.

The carry and overflow rules deliberately follow the machine's own convention rather than the textbook one. Add-with-carry reports carry when the wrapped sum is below the operand. Subtract-with-borrow reports carry when the wrapped difference is above the operand. Overflow for add, subtract and compare is the sign of (accumulator xor operand) ANDed with the sign of (accumulator xor result). The three plain shifts produce zero for amounts of 64 or more. A zero amount on any shift or rotate passes the accumulator through and leaves carry alone.

Control is a two-state machine. In IDLE the block waits. The transition IDLE->DONE happens when `start_i` is high. In DONE, `done_o` is high for the registered result. The transition DONE->DONE happens on a back-to-back request, and DONE->IDLE happens when `start_i` is low.

Top module: `acc_alu64`

## Requirements
- R1: Op code 0 (add with carry) gives result = acc + operand + carry_in, wrapped to 64 bits, with C = 1 exactly when that result is below the operand (unsigned).
- R2: Op code 1 (subtract with borrow) gives result = acc - operand - (1 - carry_in), wrapped, with C = 1 exactly when that result is above the operand (unsigned).
- R3: For op codes 0, 1 and 10, V = bit 63 of (acc xor operand) AND bit 63 of (acc xor difference-or-sum), and all four flag enables are set (flag_we_o = 4'b1111).
- R4: Op code 10 (compare) sets N, V and Z from acc - operand and sets C when acc >= operand (unsigned). It drives that difference on result_o with res_we_o = 0.
- R5: Op codes 2, 3 and 4 (AND, OR, XOR) write the bitwise result with res_we_o = 1 and flag_we_o = 4'b1010, which enables only N and Z.
- R6: For op codes 5, 6 and 7 (logical left, logical right, arithmetic right), an amount (the whole operand) of 64 or more gives result 0. Carry is then the OR of all acc bits for the left shift, and acc bit 0 for the two right shifts.
- R7: For amounts 1 to 63, the left shift (code 5) and rotate left (code 8) set C when any of the top n bits of acc is 1. Codes 6, 7 and 9 set C from acc bit 0. The enable mask is 4'b1011.
- R8: The arithmetic right shift (code 7) gives (acc >> n) with the original acc bit 63 ORed into result bit 63.
- R9: Rotate left (code 8) gives (acc << n) | carry_in. Rotate right (code 9) gives (acc >> n) with carry_in ORed into bit 64 - n. For amounts of 64 or more, both give carry_in in bit 0 and zeros above it. For such amounts C is the OR of acc for code 8, and acc bit 0 for code 9.
- R10: flags_o is {N, V, Z, C} (bit 3 down to bit 0). Z = 1 when the result is zero, and N = result bit 63. A flag bit whose enable is 0 reads as 0.
- R11: A shift or rotate amount of 0 gives result = acc, with flag_we_o = 4'b1010 so that carry is left unchanged.
- R12: Op codes 11 to 15 write nothing: res_we_o = 0, flag_we_o = 0, result_o = 0, flags_o = 0.
- R13: A request at one edge makes its outputs and done_o = 1 visible after that edge. A cycle without a request drops done_o and holds result and flag outputs. Back-to-back requests keep done_o high.
- R14: While rst_n is low, all outputs are 0 and the state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, sampled at the rising edge |
| op_i | input | 4 | Operation code |
| acc_i | input | 64 | Accumulator value |
| opnd_i | input | 64 | Operand, or shift/rotate amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 64 | Registered result |
| flags_o | output | 4 | Registered flags {N, V, Z, C} |
| flag_we_o | output | 4 | Registered per-flag write enables |
| res_we_o | output | 1 | Registered result write enable |
| done_o | output | 1 | High in the cycle after a request |

## Verification
The assertions take for granted that `op_i`, `opnd_i`, `acc_i` and `carry_i` are valid, known values whenever `start_i` is high. They make no assumption about those inputs while no request is made. The stimulus drives all request inputs together, half a cycle ahead of the capturing edge. Between requests it lowers `start_i` and leaves the data inputs alone, so every request is a clean, fully defined operation. Unused op codes are reached only through a deliberate request, so that the no-write rule is tested.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADC = 4'd0,
        OP_SBC = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_LSL = 4'd5,
        OP_LSR = 4'd6,
        OP_ASR = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9,
        OP_CMP = 4'd10
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } alu_state_e;

    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_V = 2;
    localparam int FL_N = 3;
    localparam int NFLAGS = 4;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub
    import acc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         cout,
    output logic         ovf
);

    always_comb begin
        unique case (op)
            OP_SBC: begin
                r    = a - b - W'(!cin);
                cout = (r > b);
            end
            OP_CMP: begin
                r    = a - b;
                cout = (a >= b);
            end
            default: begin
                r    = a + b + W'(cin);
                cout = (r < b);
            end
        endcase
        ovf = (a[W-1] ^ b[W-1]) & (a[W-1] ^ r[W-1]);
    end

endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);

    always_comb begin
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            default: r = a ^ b;
        endcase
    end

endmodule

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
module alu_shift
    import acc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] amt,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         cout,
    output logic         amt_zero
);

    localparam int SHW = $clog2(W);
    typedef logic [SHW:0] span_t;

    logic           big;
    logic [SHW-1:0] n;
    span_t          inv;
    logic           top_any;

    assign big      = |amt[W-1:SHW];
    assign n        = amt[SHW-1:0];
    assign amt_zero = !big && (n == '0);
    assign inv      = span_t'(W) - span_t'(n);
    assign top_any  = big ? |a : |(a >> inv);

    always_comb begin
        r    = a;
        cout = a[0];
        if (!amt_zero) begin
            unique case (op)
                OP_LSL: begin
                    r    = big ? '0 : (a << n);
                    cout = top_any;
                end
                OP_LSR: r = big ? '0 : (a >> n);
                OP_ASR: r = big ? '0 : ((a >> n) | {a[W-1], {(W-1){1'b0}}});
                OP_ROL: begin
                    r    = (big ? '0 : (a << n)) | W'(cin);
                    cout = top_any;
                end
                default: r = big ? W'(cin) : ((a >> n) | (W'(cin) << inv));
            endcase
        end
    end

endmodule

// File: rtl/acc_alu64.sv
`timescale 1ns/1ps
module acc_alu64
    import acc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  acc_i,
    input  logic [W-1:0]  opnd_i,
    input  logic          carry_i,
    output logic [W-1:0]  result_o,
    output logic [3:0]    flags_o,
    output logic [3:0]    flag_we_o,
    output logic          res_we_o,
    output logic          done_o
);

    localparam int SHW = $clog2(W);

    alu_state_e state_q, state_d;

    logic [W-1:0] as_r, lg_r, sh_r;
    logic         as_c, as_v, sh_c, sh_zero;

    logic [W-1:0] nxt_res;
    logic [3:0]   nxt_we, nxt_raw, nxt_flags;
    logic         nxt_rwe;

    alu_addsub #(.W(W)) u_addsub (
        .op(op_i), .a(acc_i), .b(opnd_i), .cin(carry_i),
        .r(as_r), .cout(as_c), .ovf(as_v)
    );

    alu_logic #(.W(W)) u_logic (
        .op(op_i), .a(acc_i), .b(opnd_i), .r(lg_r)
    );

    alu_shift #(.W(W)) u_shift (
        .op(op_i), .a(acc_i), .amt(opnd_i), .cin(carry_i),
        .r(sh_r), .cout(sh_c), .amt_zero(sh_zero)
    );

    // Operation select: result, raw flags and write masks
    always_comb begin
        nxt_res = '0;
        nxt_we  = 4'b0000;
        nxt_rwe = 1'b0;
        nxt_raw = 4'b0000;
        unique case (op_i)
            OP_ADC, OP_SBC, OP_CMP: begin
                nxt_res       = as_r;
                nxt_we        = 4'b1111;
                nxt_rwe       = (op_i != OP_CMP);
                nxt_raw[FL_C] = as_c;
                nxt_raw[FL_V] = as_v;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_res = lg_r;
                nxt_we  = 4'b1010;
                nxt_rwe = 1'b1;
            end
            OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
                nxt_res       = sh_r;
                nxt_we        = sh_zero ? 4'b1010 : 4'b1011;
                nxt_rwe       = 1'b1;
                nxt_raw[FL_C] = sh_c;
            end
            default: ;
        endcase
        nxt_raw[FL_Z] = (nxt_res == '0);
        nxt_raw[FL_N] = nxt_res[W-1];
        nxt_flags     = nxt_raw & nxt_we;
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start_i ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            flags_o   <= '0;
            flag_we_o <= '0;
            res_we_o  <= 1'b0;
        end else if (start_i) begin
            result_o  <= nxt_res;
            flags_o   <= nxt_flags;
            flag_we_o <= nxt_we;
            res_we_o  <= nxt_rwe;
        end
    end

    assign done_o = (state_q == ST_DONE);

    // Assertions
    assert_done_follows_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_done_drops_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    assert_hold_when_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(result_o) && $stable(flags_o)));

    assert_logic_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR))
        |=> (flag_we_o == 4'b1010 && res_we_o));

    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_CMP) |=> (!res_we_o && flag_we_o == 4'b1111));

    assert_wide_shift_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (op_i == OP_LSL || op_i == OP_LSR || op_i == OP_ASR) && (|opnd_i[W-1:SHW]))
        |=> (result_o == '0));

    assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && res_we_o && flag_we_o[FL_Z]) |-> (flags_o[FL_Z] == (result_o == '0)));

    assert_unknown_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i > OP_CMP) |=> (flag_we_o == 4'b0000 && !res_we_o));

    assert_shift_zero_amt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i >= OP_LSL && op_i <= OP_ROR && opnd_i == '0)
        |=> (result_o == $past(acc_i) && !flag_we_o[FL_C]));

endmodule

// File: tb/acc_alu64_bench.sv
`timescale 1ns/1ps
module acc_alu64_bench;

    typedef struct packed {
        logic [3:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic        c;
        logic [63:0] res;
        logic [3:0]  fl;
        logic [3:0]  we;
        logic        rwe;
        logic [3:0]  rq;
    } vec_t;

    localparam int VN = 24;
    localparam vec_t VECS [VN] = '{
        // R1 plain add with carry in
        '{4'd0, 64'd1, 64'd2, 1'b1, 64'd4, 4'b0000, 4'b1111, 1'b1, 4'd1},
        // R1/R3 wrap: carry set, overflow set by this convention
        '{4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 64'd0, 4'b0111, 4'b1111, 1'b1, 4'd3},
        // R3 sign change without overflow by this convention
        '{4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b0, 64'h8000_0000_0000_0000, 4'b1000, 4'b1111, 1'b1, 4'd3},
        // R2 subtract, carry when result above operand
        '{4'd1, 64'd10, 64'd3, 1'b1, 64'd7, 4'b0001, 4'b1111, 1'b1, 4'd2},
        // R2 borrow in, wraps
        '{4'd1, 64'd5, 64'd5, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1001, 4'b1111, 1'b1, 4'd2},
        // R4 compare equal
        '{4'd10, 64'd5, 64'd5, 1'b0, 64'd0, 4'b0011, 4'b1111, 1'b0, 4'd4},
        // R4 compare below
        '{4'd10, 64'd3, 64'd5, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 4'b1000, 4'b1111, 1'b0, 4'd4},
        // R5 AND
        '{4'd2, 64'hF0F0, 64'hFF00, 1'b1, 64'hF000, 4'b0000, 4'b1010, 1'b1, 4'd5},
        // R5 XOR to zero
        '{4'd4, 64'hAAAA, 64'hAAAA, 1'b0, 64'd0, 4'b0010, 4'b1010, 1'b1, 4'd5},
        // R10 OR negative
        '{4'd3, 64'h8000_0000_0000_0000, 64'd1, 1'b0, 64'h8000_0000_0000_0001, 4'b1000, 4'b1010, 1'b1, 4'd10},
        // R7 left shift by 1, top bit to carry
        '{4'd5, 64'h8000_0000_0000_0001, 64'd1, 1'b0, 64'd2, 4'b0001, 4'b1011, 1'b1, 4'd7},
        // R6 left shift by 64
        '{4'd5, 64'd1, 64'd64, 1'b0, 64'd0, 4'b0011, 4'b1011, 1'b1, 4'd6},
        // R7 logical right
        '{4'd6, 64'd3, 64'd1, 1'b0, 64'd1, 4'b0001, 4'b1011, 1'b1, 4'd7},
        // R6 logical right by 100
        '{4'd6, 64'd2, 64'd100, 1'b1, 64'd0, 4'b0010, 4'b1011, 1'b1, 4'd6},
        // R8 arithmetic right keeps sign
        '{4'd7, 64'h8000_0000_0000_0004, 64'd2, 1'b0, 64'hA000_0000_0000_0001, 4'b1000, 4'b1011, 1'b1, 4'd8},
        // R6 arithmetic right by 64
        '{4'd7, 64'h8000_0000_0000_0000, 64'd64, 1'b0, 64'd0, 4'b0010, 4'b1011, 1'b1, 4'd6},
        // R9 rotate left
        '{4'd8, 64'h8000_0000_0000_0000, 64'd1, 1'b1, 64'd1, 4'b0001, 4'b1011, 1'b1, 4'd9},
        // R9 rotate right carry into bit 63
        '{4'd9, 64'd1, 64'd1, 1'b1, 64'h8000_0000_0000_0000, 4'b1001, 4'b1011, 1'b1, 4'd9},
        // R9 rotate right by 4
        '{4'd9, 64'h10, 64'd4, 1'b0, 64'd1, 4'b0000, 4'b1011, 1'b1, 4'd9},
        // R9 rotate left by 70
        '{4'd8, 64'd1, 64'd70, 1'b1, 64'd1, 4'b0001, 4'b1011, 1'b1, 4'd9},
        // R11 zero amount shift
        '{4'd5, 64'd5, 64'd0, 1'b1, 64'd5, 4'b0000, 4'b1010, 1'b1, 4'd11},
        // R11 zero amount rotate
        '{4'd8, 64'd0, 64'd0, 1'b1, 64'd0, 4'b0010, 4'b1010, 1'b1, 4'd11},
        // R12 unused code 15
        '{4'd15, 64'd5, 64'd5, 1'b1, 64'd0, 4'b0000, 4'b0000, 1'b0, 4'd12},
        // R12 unused code 11
        '{4'd11, 64'hFFFF, 64'd0, 1'b0, 64'd0, 4'b0000, 4'b0000, 1'b0, 4'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] acc_i = '0;
    logic [63:0] opnd_i = '0;
    logic        carry_i = 1'b0;
    logic [63:0] result_o;
    logic [3:0]  flags_o;
    logic [3:0]  flag_we_o;
    logic        res_we_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acc_alu64 u_acc_alu64 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i),
        .result_o(result_o), .flags_o(flags_o), .flag_we_o(flag_we_o),
        .res_we_o(res_we_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic request(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b, input logic c);
        @(negedge clk);
        op_i = op; acc_i = a; opnd_i = b; carry_i = c; start_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R14 reset state
        chk("R14", "result", result_o, 64'd0);
        chk("R14", "flags", 64'(flags_o), 64'd0);
        chk("R14", "done", 64'(done_o), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < VN; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].rq);
            request(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].c);
            @(negedge clk);
            start_i = 1'b0;
            chk(tag, $sformatf("vec%0d result", i), result_o, VECS[i].res);
            chk(tag, $sformatf("vec%0d flags", i), 64'(flags_o), 64'(VECS[i].fl));
            chk(tag, $sformatf("vec%0d flag_we", i), 64'(flag_we_o), 64'(VECS[i].we));
            chk(tag, $sformatf("vec%0d res_we", i), 64'(res_we_o), 64'(VECS[i].rwe));
            chk("R13", $sformatf("vec%0d done", i), 64'(done_o), 64'd1);
        end

        // R13 hold: last vector left outputs at zero; load a known value first
        request(4'd2, 64'h1234, 64'hFFFF, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        acc_i = 64'hDEAD;
        @(negedge clk);
        chk("R13", "done after idle", 64'(done_o), 64'd0);
        chk("R13", "result held", result_o, 64'h1234);

        // R13 back-to-back requests
        request(4'd0, 64'd100, 64'd1, 1'b0);
        @(negedge clk);
        chk("R13", "b2b first result", result_o, 64'd101);
        chk("R13", "b2b first done", 64'(done_o), 64'd1);
        op_i = 4'd1; acc_i = 64'd100; opnd_i = 64'd1; carry_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R13", "b2b second result", result_o, 64'd99);
        chk("R13", "b2b second done", 64'(done_o), 64'd1);
        @(negedge clk);
        chk("R13", "b2b done drops", 64'(done_o), 64'd0);

        // R14 reset after activity
        request(4'd3, 64'd7, 64'd8, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R14", "result after reset", result_o, 64'd0);
        chk("R14", "flag_we after reset", 64'(flag_we_o), 64'd0);
        chk("R14", "done after reset", 64'(done_o), 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule